// File: doc/BRIEF.md
# Programmable Integer Clock Divider with Start-Phase Offset

This block divides one input clock by an integer ratio for a single output channel. The high phase and the low phase are programmed separately. A high-phase count `N` gives `N + 1` input cycles high, and a low-phase count `M` gives `M + 1` input cycles low, so the total ratio is `N + M + 2`. The output waveform starts from an alignment event, the synchronisation input. Its first rising edge can be pushed back by a programmed number of input cycles. This lets several such channels be lined up against one another with a known skew.

The delay is chosen by a 5-bit phase code made of the start-high flag (the upper bit) and a 4-bit offset. With the flag clear, the delay equals the offset. With the flag set, the delay is the offset plus `M + 1`. A bypass control routes the input clock straight to the output. An optional duty-cycle correction makes odd ratios close to 50%. It holds the output high for an extra half input period, using a register clocked on the opposite input edge. It only acts when `M = N + 1`.

Settings are taken at two points only: while the synchronisation input is high, and at the boundary between one output period and the next. The output therefore never shows a shortened pulse.

Top module: `clk_phase_divider`

## Requirements
- R1: After reset `clk_out` is low. It stays low, with no divided edges, until a synchronisation pulse has been seen and released, provided bypass is off.
- R2: With correction inactive, the divided output stays high for exactly `high_cnt + 1` input cycles. It then stays low for exactly `low_cnt + 1` input cycles, and this repeats.
- R3: Edge 0 is the first input rising edge at which `sync_in` is sampled low after being high. With `start_high = 0`, the output first rises at edge `phase_off`, so an offset of 0 means it rises at edge 0 itself.
- R4: With `start_high = 1`, the first rise comes at edge `phase_off + low_cnt + 1`. The phase code is `16*start_high + phase_off`, and the delay equals code − 16 + `low_cnt` + 1.
- R5: While `sync_in` is high, the output is held low on every rising edge and the period position is cleared. A change of `phase_off` or `start_high` made without a synchronisation pulse does not alter the running waveform.
- R6: While `bypass = 1`, `clk_out` equals `clk_in`. This holds in both the high and the low half of every input cycle.
- R7: With `dcc_en = 1` and `low_cnt = high_cnt + 1`, each high phase of the output lasts an extra half input period. The output falls at the input falling edge that follows the rising edge where the uncorrected output would fall.
- R8: With `dcc_en = 1` but `low_cnt != high_cnt + 1`, the waveform is the same as with correction off. An even ratio with `low_cnt = high_cnt` is then 50%.
- R9: A new `high_cnt`, `low_cnt` or `dcc_en` value presented while the divider runs takes effect only at the rising edge that begins a new high phase. Before that edge, the old high and low lengths are finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Alignment control; high holds the output low, and its release starts the delay count |
| bypass | input | 1 | High routes `clk_in` directly to `clk_out` |
| dcc_en | input | 1 | Enables half-cycle duty-cycle correction for odd ratios |
| start_high | input | 1 | Upper bit of the phase code; selects the delay formula that includes the low count |
| phase_off | input | CNT_W | Lower bits of the phase code |
| high_cnt | input | CNT_W | High-phase count N (high lasts N + 1 input cycles) |
| low_cnt | input | CNT_W | Low-phase count M (low lasts M + 1 input cycles) |
| clk_out | output | 1 | Divided, delayed or bypassed output clock |

## Verification
Four properties are checked on every input cycle:
- every completed high phase of the divided signal lasts exactly N + 1 cycles;
- a high `sync_in` forces the divided signal low on the next edge;
- the latched ratio settings do not move during a high phase;
- the first rise after a release lands exactly on the cycle given by the phase code and the low count.

The low-phase length, the half-cycle extension, the bypass path and the claim that an unsynchronised phase change has no effect can only be shown by the bench. Its reference model is compared with `clk_out` in both halves of every input cycle, across a range of ratios, offsets and settings changed mid-run.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARMED = 3'd1,
      ST_DELAY = 3'd2,
      ST_HIGH  = 3'd3,
      ST_LOW   = 3'd4
   } div_state_e;

   // Cycles from release to first rise, written from the phase-code rule.
   function automatic int phase_delay(input int code, input int low, input int cnt_w);
      int half;
      half = 1 << cnt_w;
      if (code < half) return code;
      return code - half + low + 1;
   endfunction

endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg #(
   parameter int CNT_W   = 4,
   parameter bit HAS_DCC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_all,
   input  logic             load_ratio,
   input  logic [CNT_W-1:0] n_in,
   input  logic [CNT_W-1:0] m_in,
   input  logic [CNT_W-1:0] po_in,
   input  logic             sh_in,
   input  logic             dcc_in,
   output logic [CNT_W-1:0] n_q,
   output logic [CNT_W-1:0] m_q,
   output logic [CNT_W-1:0] po_q,
   output logic             sh_q,
   output logic             dcc_act
);

   logic load_any;
   assign load_any = load_all | load_ratio;

   // ratio fields: taken at alignment or at a period boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q <= '0;
         m_q <= '0;
      end else if (load_any) begin
         n_q <= n_in;
         m_q <= m_in;
      end
   end

   // phase fields: taken at alignment only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         po_q <= '0;
         sh_q <= 1'b0;
      end else if (load_all) begin
         po_q <= po_in;
         sh_q <= sh_in;
      end
   end

   generate
      if (HAS_DCC) begin : g_dcc
         logic dcc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dcc_q <= 1'b0;
            else if (load_any)
               dcc_q <= dcc_in;
         end
         assign dcc_act = dcc_q && ({1'b0, m_q} == ({1'b0, n_q} + 1'b1));
      end else begin : g_no_dcc
         logic unused_dcc;
         assign unused_dcc = dcc_in;
         assign dcc_act    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
   import clkdiv_pkg::*;
#(
   parameter int CNT_W = 4,
   localparam int DLY_W = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_in,
   input  logic [CNT_W-1:0] n_cfg,
   input  logic [CNT_W-1:0] m_cfg,
   input  logic [CNT_W-1:0] po_cfg,
   input  logic             sh_cfg,
   input  logic [CNT_W-1:0] n_next,
   output logic             load_ratio,
   output logic             div_q
);

   div_state_e       st;
   logic [DLY_W-1:0] cnt;
   logic [DLY_W-1:0] dly;
   logic             cnt_zero;

   // start delay: the offset alone, or offset plus low length when start-high is set
   always_comb begin
      if (sh_cfg)
         dly = {1'b0, po_cfg} + {1'b0, m_cfg} + DLY_W'(1);
      else
         dly = {1'b0, po_cfg};
   end

   assign cnt_zero   = (cnt == '0);
   assign load_ratio = !sync_in && (st == ST_LOW) && cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         div_q <= 1'b0;
      end else if (sync_in) begin
         st    <= ST_ARMED;
         cnt   <= '0;
         div_q <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               st <= ST_IDLE;
            end
            ST_ARMED: begin
               if (dly == '0) begin
                  div_q <= 1'b1;
                  st    <= ST_HIGH;
                  cnt   <= {1'b0, n_cfg};
               end else begin
                  st  <= ST_DELAY;
                  cnt <= dly - DLY_W'(1);
               end
            end
            ST_DELAY: begin
               if (cnt_zero) begin
                  div_q <= 1'b1;
                  st    <= ST_HIGH;
                  cnt   <= {1'b0, n_cfg};
               end else begin
                  cnt <= cnt - DLY_W'(1);
               end
            end
            ST_HIGH: begin
               if (cnt_zero) begin
                  div_q <= 1'b0;
                  st    <= ST_LOW;
                  cnt   <= {1'b0, m_cfg};
               end else begin
                  cnt <= cnt - DLY_W'(1);
               end
            end
            ST_LOW: begin
               if (cnt_zero) begin
                  div_q <= 1'b1;
                  st    <= ST_HIGH;
                  cnt   <= {1'b0, n_next};
               end else begin
                  cnt <= cnt - DLY_W'(1);
               end
            end
            default: begin
               st    <= ST_IDLE;
               div_q <= 1'b0;
            end
         endcase
      end
   end

   // checker state: run length of high output and cycles since release
   logic [DLY_W:0]   hi_len;
   logic [DLY_W+1:0] rel_cnt;
   logic             seen_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len    <= '0;
         rel_cnt   <= '0;
         seen_rise <= 1'b0;
      end else begin
         hi_len <= div_q ? hi_len + 1'b1 : '0;
         if (sync_in)
            rel_cnt <= '0;
         else if (rel_cnt != '1)
            rel_cnt <= rel_cnt + 1'b1;
         if (sync_in)
            seen_rise <= 1'b0;
         else if (div_q)
            seen_rise <= 1'b1;
      end
   end

   assert_high_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(div_q) && !$past(sync_in)) |-> (int'(hi_len) == int'(n_cfg) + 1));

   assert_sync_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sync_in |=> !div_q);

   assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q && !sync_in) |=> ($stable(n_cfg) && $stable(m_cfg)));

   // covers R4 as well: the code includes the start-high bit
   assert_first_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(div_q) && !seen_rise) |->
      (int'(rel_cnt) == phase_delay(int'({sh_cfg, po_cfg}), int'(m_cfg), CNT_W) + 1));

endmodule

// File: rtl/clkdiv_outstage.sv
module clkdiv_outstage (
   input  logic clk,
   input  logic rst_n,
   input  logic bypass,
   input  logic dcc_act,
   input  logic div_q,
   output logic clk_out
);

   logic q_neg;
   logic div_ext;

   // opposite-edge copy stretches the high phase by half an input period
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         q_neg <= 1'b0;
      else
         q_neg <= div_q;
   end

   assign div_ext = div_q | (dcc_act & q_neg);
   assign clk_out = bypass ? clk : div_ext;

endmodule

// File: rtl/clk_phase_divider.sv
module clk_phase_divider #(
   parameter int CNT_W   = 4,
   parameter bit HAS_DCC = 1'b1
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic             sync_in,
   input  logic             bypass,
   input  logic             dcc_en,
   input  logic             start_high,
   input  logic [CNT_W-1:0] phase_off,
   input  logic [CNT_W-1:0] high_cnt,
   input  logic [CNT_W-1:0] low_cnt,
   output logic             clk_out
);

   generate
      if (CNT_W < 2 || CNT_W > 8) begin : g_bad_width
         $error("clk_phase_divider: CNT_W must lie in 2..8");
      end
   endgenerate

   logic [CNT_W-1:0] n_q, m_q, po_q;
   logic             sh_q;
   logic             dcc_act;
   logic             load_ratio;
   logic             div_q;

   clkdiv_cfg #(.CNT_W(CNT_W), .HAS_DCC(HAS_DCC)) u_cfg (
      .clk        (clk_in),
      .rst_n      (rst_n),
      .load_all   (sync_in),
      .load_ratio (load_ratio),
      .n_in       (high_cnt),
      .m_in       (low_cnt),
      .po_in      (phase_off),
      .sh_in      (start_high),
      .dcc_in     (dcc_en),
      .n_q        (n_q),
      .m_q        (m_q),
      .po_q       (po_q),
      .sh_q       (sh_q),
      .dcc_act    (dcc_act)
   );

   clkdiv_core #(.CNT_W(CNT_W)) u_core (
      .clk        (clk_in),
      .rst_n      (rst_n),
      .sync_in    (sync_in),
      .n_cfg      (n_q),
      .m_cfg      (m_q),
      .po_cfg     (po_q),
      .sh_cfg     (sh_q),
      .n_next     (high_cnt),
      .load_ratio (load_ratio),
      .div_q      (div_q)
   );

   clkdiv_outstage u_out (
      .clk     (clk_in),
      .rst_n   (rst_n),
      .bypass  (bypass),
      .dcc_act (dcc_act),
      .div_q   (div_q),
      .clk_out (clk_out)
   );

endmodule

// File: tb/clk_phase_divider_test.sv
`timescale 1ns/1ps
module clk_phase_divider_test;

   logic       clk_in = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_in = 1'b0;
   logic       bypass = 1'b0;
   logic       dcc_en = 1'b0;
   logic       start_high = 1'b0;
   logic [3:0] phase_off = '0;
   logic [3:0] high_cnt = '0;
   logic [3:0] low_cnt = '0;
   logic       clk_out;

   int checks = 0;
   int fails = 0;
   bit done = 0;
   string req = "R1";

   clk_phase_divider uut (
      .clk_in(clk_in), .rst_n(rst_n), .sync_in(sync_in), .bypass(bypass),
      .dcc_en(dcc_en), .start_high(start_high), .phase_off(phase_off),
      .high_cnt(high_cnt), .low_cnt(low_cnt), .clk_out(clk_out)
   );

   always #10 clk_in = ~clk_in;

   // behavioural reference
   int  mn, mm, mdcc, dl, ph;
   bit  armed, running, first;
   bit  mq, mq_prev, m_dcc_act;

   task automatic step();
      if (dl > 0) begin
         dl = dl - 1;
         mq = 0;
      end else begin
         if (ph == 0 && !first) begin
            mn = high_cnt; mm = low_cnt; mdcc = dcc_en;
         end
         first = 0;
         mq = (ph < mn + 1);
         ph = (ph + 1) % (mn + mm + 2);
      end
   endtask

   always @(posedge clk_in) begin
      mq_prev = mq;
      if (!rst_n) begin
         mq = 0; armed = 0; running = 0; mn = 0; mm = 0; mdcc = 0;
      end else if (sync_in) begin
         int code;
         armed = 1; running = 0; mq = 0;
         mn = high_cnt; mm = low_cnt; mdcc = dcc_en;
         code = 16 * start_high + phase_off;
         dl = (code <= 15) ? code : code - 16 + mm + 1;
      end else if (armed) begin
         armed = 0; running = 1; first = 1; ph = 0;
         step();
      end else if (running) begin
         step();
      end
      m_dcc_act = (mdcc != 0) && (mm == mn + 1);
   end

   task automatic check(input bit exp);
      checks++;
      if (clk_out !== exp) begin
         fails++;
         $display("FAIL %s at %0t: clk_out=%b expected=%b", req, $time, clk_out, exp);
      end
   endtask

   // sample mid-high and mid-low of every input cycle
   initial begin
      forever begin
         @(posedge clk_in); #5;
         check(!rst_n ? 1'b0 : bypass ? 1'b1 : (mq | (m_dcc_act & mq_prev)));
         @(negedge clk_in); #5;
         check(!rst_n ? 1'b0 : bypass ? 1'b0 : mq);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk_in);
      #2;
   endtask

   task automatic run(input string r, input int n, input int m, input int po,
                      input bit sh, input bit dcc, input int len);
      req = r;
      high_cnt = 4'(n); low_cnt = 4'(m); phase_off = 4'(po);
      start_high = sh; dcc_en = dcc;
      sync_in = 1; cyc(2);
      sync_in = 0; cyc(len);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog expired during %s", req);
      finish_up();
   end

   initial begin
      cyc(3);
      rst_n = 1;                       // R1: low and inert without a sync pulse
      high_cnt = 4'd1; cyc(12);
      run("R2", 2, 4, 0, 0, 0, 40);
      run("R2", 0, 0, 0, 0, 0, 20);
      run("R2", 15, 15, 0, 0, 0, 80);
      run("R3", 3, 3, 5, 0, 0, 40);
      run("R3", 1, 2, 15, 0, 0, 40);
      run("R4", 2, 3, 0, 1, 0, 40);
      run("R4", 1, 15, 15, 1, 0, 80);
      run("R5", 2, 2, 3, 0, 0, 20);
      phase_off = 4'd9; start_high = 1; cyc(30);   // R5: ignored without sync
      sync_in = 1; cyc(5); sync_in = 0; cyc(40);   // R5: re-align with new phase
      req = "R6"; bypass = 1; cyc(20); bypass = 0;
      run("R7", 2, 3, 1, 0, 1, 50);
      run("R7", 0, 1, 0, 0, 1, 30);
      run("R8", 3, 3, 0, 0, 1, 40);
      run("R8", 2, 5, 2, 0, 1, 40);
      run("R9", 1, 2, 0, 0, 0, 7);
      high_cnt = 4'd4; low_cnt = 4'd1; cyc(40);
      dcc_en = 1; high_cnt = 4'd1; low_cnt = 4'd2; cyc(40);
      finish_up();
   end

endmodule